// File: doc/BRIEF.md
# Uplink Long Gold Scrambling Code Generator

This block produces the complex long scrambling code for an uplink transmitter. It presents one chip at a time. Each chip is a pair of sign bits, one for the in-phase rail and one for the quadrature rail. Two 25-stage binary shift registers, both in Fibonacci form, run in lockstep. One register is seeded from a 24-bit code number and the other is seeded with all ones. The XOR of their first stages is the primary Gold chip.

A second Gold sequence is also needed. It is the primary sequence read 16777232 chips ahead. The block takes it from the same two registers, as the parity of a fixed set of stages in each register. The parameters `XMASK` and `YMASK` select those stages. The quadrature rail combines the primary chip, an alternating sign, and the second sequence held over each even/odd chip pair.

A load strobe latches the code number and a start-offset selector. With the selector low, the frame starts at sequence chip 0. With the selector high, the frame starts at sequence chip 4096, as used for a random-access message part. To reach that offset, the registers free-run for 4096 clocks with no output, and `busy` stays high during that time. A frame is 38400 chips long. When the last chip of a frame is consumed, the registers reload from the latched code number and selector.

Top module: `ul_long_scrambler`

## Requirements
- R1: At load, x-register stages 0..23 take code number bits 0..23 (bit 0 in stage 0) and stage 24 takes 1. The x sequence then follows x(i+25) = x(i+3) XOR x(i).
- R2: At load, all 25 y-register stages take 1. The y sequence follows y(i+25) = y(i+3) XOR y(i+2) XOR y(i+1) XOR y(i). `chip_i` is x(i) XOR y(i), where bit 1 stands for −1 and bit 0 stands for +1.
- R3: `chip_q` is `chip_i` XOR (frame chip index odd) XOR c2(e). Here c2 is the Gold sequence advanced by 16777232 chips modulo 2^25−1, and e is the even index of the current chip pair.
- R4: While running, with `chip_en` low and no load, the outputs and the chip position do not change.
- R5: A load with `msg_mode` low makes chip 0 of the new code available on the next cycle, with `busy` low.
- R6: A load with `msg_mode` high keeps `busy` high for exactly 4096 clocks whatever `chip_en` does. The first chip shown after that is sequence chip 4096.
- R7: `frame_end` is high exactly while frame chip 38399 is shown.
- R8: Consuming frame chip 38399 reloads the latched code. The next chip is sequence chip 0, or the block first goes through the 4096-clock skip of R6 if the latched selector is high.
- R9: After reset, `busy` is high and `chip_i`, `chip_q` and `frame_end` are 0 until the first load, whatever `chip_en` does. Whenever `busy` is high these three outputs are 0.
- R10: A load in the same cycle as `chip_en` takes priority and restarts from the new code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load | input | 1 | Latch code and selector, restart the frame |
| msg_mode | input | 1 | 1 = start each frame at sequence chip 4096 |
| code_num | input | 24 | Scrambling code number |
| chip_en | input | 1 | Consume the shown chip and advance to the next |
| chip_i | output | 1 | In-phase sign bit (1 = −1) |
| chip_q | output | 1 | Quadrature sign bit (1 = −1) |
| frame_end | output | 1 | Shown chip is the last of the frame |
| busy | output | 1 | No valid chip is shown |

## Verification
The bench keeps its own model of both shift registers. It computes the 16777232-chip advance as a polynomial power modulo each register's characteristic polynomial, so a wrong stage mask shows up as `chip_q` mismatches soon after load.

The corner cases it targets are these:
- A full frame in both start modes, so a frame counter off by one moves `frame_end` or repeats a chip.
- The odd half of each chip pair, so a design that does not hold the second sequence, or drops the sign alternation, fails on every odd chip.
- The 4096-clock skip, counted exactly, so one clock too few or too many shifts the whole code.
- `chip_en` held high before the first load, during the skip, and together with a load, which catches a design that advances when it should not or gives the load too low a priority.

// File: rtl/ul_long_scrambler.sv
module ul_long_scrambler #(
  parameter int          FRAME_LEN  = 38400,
  parameter int          MSG_OFFSET = 4096,
  parameter logic [24:0] XMASK      = 25'h0040090,
  parameter logic [24:0] YMASK      = 25'h0020050
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        load,
  input  logic        msg_mode,
  input  logic [23:0] code_num,
  input  logic        chip_en,
  output logic        chip_i,
  output logic        chip_q,
  output logic        frame_end,
  output logic        busy
);

  localparam int CW = $clog2((FRAME_LEN > MSG_OFFSET) ? FRAME_LEN : MSG_OFFSET);
  localparam logic [CW-1:0] LAST_CHIP = CW'(FRAME_LEN - 1);
  localparam logic [CW-1:0] LAST_SKIP = CW'(MSG_OFFSET - 1);
  localparam logic [CW-1:0] ONE       = CW'(1);

  typedef enum logic [1:0] {ST_IDLE, ST_SKIP, ST_RUN} st_t;

  st_t           st;
  logic [24:0]   xr, yr;
  logic [23:0]   code_q;
  logic          mode_q;
  logic [CW-1:0] cnt;
  logic          c2_hold;

  wire [24:0] x_next  = {xr[3] ^ xr[0], xr[24:1]};
  wire [24:0] y_next  = {yr[3] ^ yr[2] ^ yr[1] ^ yr[0], yr[24:1]};
  wire        running = (st == ST_RUN);
  wire        z1      = xr[0] ^ yr[0];
  wire        c2_live = (^(xr & XMASK)) ^ (^(yr & YMASK));
  wire        wrap    = running && chip_en && (cnt == LAST_CHIP);

  assign busy      = !running;
  assign chip_i    = running & z1;
  assign chip_q    = running & (z1 ^ cnt[0] ^ (cnt[0] ? c2_hold : c2_live));
  assign frame_end = running & (cnt == LAST_CHIP);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      xr      <= '0;
      yr      <= '0;
      code_q  <= '0;
      mode_q  <= 1'b0;
      cnt     <= '0;
      c2_hold <= 1'b0;
    end else if (load) begin
      code_q  <= code_num;
      mode_q  <= msg_mode;
      xr      <= {1'b1, code_num};
      yr      <= '1;
      cnt     <= '0;
      c2_hold <= 1'b0;
      st      <= msg_mode ? ST_SKIP : ST_RUN;
    end else if (wrap) begin
      xr      <= {1'b1, code_q};
      yr      <= '1;
      cnt     <= '0;
      c2_hold <= 1'b0;
      st      <= mode_q ? ST_SKIP : ST_RUN;
    end else if (st == ST_SKIP) begin
      xr <= x_next;
      yr <= y_next;
      if (cnt == LAST_SKIP) begin
        cnt <= '0;
        st  <= ST_RUN;
      end else begin
        cnt <= cnt + ONE;
      end
    end else if (running && chip_en) begin
      xr  <= x_next;
      yr  <= y_next;
      cnt <= cnt + ONE;
      if (!cnt[0]) c2_hold <= c2_live;
    end
  end

  a_r5_load_runs: assert property (@(posedge clk) disable iff (!rst_n)
    load && !msg_mode |=> !busy && (cnt == '0));

  a_r6_load_skips: assert property (@(posedge clk) disable iff (!rst_n)
    load && msg_mode |=> busy);

  a_r6_skip_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_SKIP) |-> (cnt <= LAST_SKIP));

  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !chip_en && !load |=> !busy && $stable(chip_i) && $stable(chip_q) && $stable(cnt));

  a_r7_end_valid: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |-> !busy);

  a_r8_wrap_restart: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end && chip_en && !load |=> (cnt == '0) && !frame_end);

  a_r3_pair_step: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && chip_en && !load && !cnt[0] |=> cnt[0] && !busy);

  a_r9_idle_stays: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE) && !load |=> busy);

endmodule

// File: tb/ul_long_scrambler_tb.sv
module ul_long_scrambler_tb;
  localparam int FL = 38400;
  localparam int MO = 4096;

  logic clk = 1'b0, rst_n = 1'b0, load = 1'b0, msg_mode = 1'b0, chip_en = 1'b0;
  logic [23:0] code_num = '0;
  logic chip_i, chip_q, frame_end, busy;

  ul_long_scrambler u_dut (
    .clk(clk), .rst_n(rst_n), .load(load), .msg_mode(msg_mode), .code_num(code_num),
    .chip_en(chip_en), .chip_i(chip_i), .chip_q(chip_q), .frame_end(frame_end), .busy(busy)
  );

  always #10 clk = ~clk;

  int total = 0, bad = 0;
  logic [24:0] mx, my, jx, jy;
  logic        mhold, mmode;
  logic [23:0] mcode;
  int          midx;

  function automatic logic [24:0] mul_t(logic [24:0] a, logic [24:0] low);
    return {a[23:0], 1'b0} ^ (a[24] ? low : 25'h0);
  endfunction

  function automatic logic [24:0] mulmod(logic [24:0] a, logic [24:0] b, logic [24:0] low);
    logic [24:0] r = '0;
    for (int k = 24; k >= 0; k--) begin
      r = mul_t(r, low);
      if (b[k]) r = r ^ a;
    end
    return r;
  endfunction

  function automatic logic [24:0] powmod(logic [31:0] e, logic [24:0] low);
    logic [24:0] r = 25'h1;
    for (int k = 31; k >= 0; k--) begin
      r = mulmod(r, r, low);
      if (e[k]) r = mulmod(r, 25'h2, low);
    end
    return r;
  endfunction

  function automatic logic c2ref();
    return (^(mx & jx)) ^ (^(my & jy));
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h (chip %0d)", tag, act, exp, midx);
    end
  endtask

  task automatic mreload();
    mx = {1'b1, mcode}; my = '1; midx = 0; mhold = 1'b0;
  endtask

  task automatic madv();
    if (midx % 2 == 0) mhold = c2ref();
    mx = {mx[3] ^ mx[0], mx[24:1]};
    my = {my[3] ^ my[2] ^ my[1] ^ my[0], my[24:1]};
    midx++;
  endtask

  task automatic check_chip(string tag);
    logic ei, eq;
    ei = mx[0] ^ my[0];
    eq = ei ^ (midx % 2 == 1) ^ ((midx % 2 == 1) ? mhold : c2ref());
    chk({tag, " R1 R2 chip_i"}, 32'(chip_i), 32'(ei));
    chk({tag, " R3 chip_q"}, 32'(chip_q), 32'(eq));
    chk({tag, " R7 frame_end"}, 32'(frame_end), 32'(midx == FL - 1));
    chk({tag, " busy"}, 32'(busy), 32'd0);
  endtask

  task automatic run(int n, string tag);
    for (int k = 0; k < n; k++) begin
      check_chip(tag);
      chip_en = 1'b1;
      @(negedge clk);
      if (midx == FL - 1) mreload(); else madv();
    end
    chip_en = 1'b0;
  endtask

  task automatic do_load(logic [23:0] c, logic m, logic en);
    load = 1'b1; code_num = c; msg_mode = m; chip_en = en;
    @(negedge clk);
    load = 1'b0; chip_en = 1'b0;
    mcode = c; mmode = m;
    mreload();
  endtask

  task automatic wait_skip(string tag);
    chk({tag, " R6 busy at skip start"}, 32'(busy), 32'd1);
    chk({tag, " R9 quiet while busy"}, {chip_i, chip_q, frame_end}, 32'd0);
    chip_en = 1'b1;
    for (int j = 1; j <= MO; j++) begin
      if (j == MO) chip_en = 1'b0;
      @(negedge clk);
      if (j == MO - 1) chk({tag, " R6 busy last skip clock"}, 32'(busy), 32'd1);
      if (j == MO)     chk({tag, " R6 ready after 4096"}, 32'(busy), 32'd0);
    end
    repeat (MO) madv();
    midx = 0; mhold = 1'b0;
  endtask

  task automatic t_reset_idle();
    chk("R9 reset busy", 32'(busy), 32'd1);
    chk("R9 reset outputs", {chip_i, chip_q, frame_end}, 32'd0);
    chip_en = 1'b1;
    repeat (6) @(negedge clk);
    chip_en = 1'b0;
    chk("R9 idle busy with enable", 32'(busy), 32'd1);
    chk("R9 idle outputs", {chip_i, chip_q, frame_end}, 32'd0);
  endtask

  task automatic t_dpch_codes();
    do_load(24'h000000, 1'b0, 1'b0); run(600, "R5 code0");
    do_load(24'hABCDEF, 1'b0, 1'b0); run(400, "R1 codeABCDEF");
    do_load(24'hFFFFFF, 1'b0, 1'b0); run(400, "R1 codeFFFFFF");
    do_load(24'h000001, 1'b0, 1'b0); run(300, "R2 code1");
  endtask

  task automatic t_hold();
    do_load(24'h5A5A5A, 1'b0, 1'b0);
    run(7, "R4 before hold");
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      check_chip("R4 hold");
    end
    run(6, "R4 after hold");
  endtask

  task automatic t_load_priority();
    do_load(24'h111111, 1'b0, 1'b0);
    run(11, "R10 pre");
    do_load(24'h2468AC, 1'b0, 1'b1);
    run(20, "R10 new code");
  endtask

  task automatic t_dpch_wrap();
    do_load(24'h123456, 1'b0, 1'b0);
    run(FL, "R8 dpch frame");
    run(50, "R8 dpch after wrap");
  endtask

  task automatic t_msg();
    do_load(24'h000ABC, 1'b1, 1'b0);
    wait_skip("R6 msg");
    run(300, "R6 msg chips");
    do_load(24'h3C3C3C, 1'b1, 1'b1);
    wait_skip("R6 msg2");
    run(FL - 1, "R8 msg frame");
    check_chip("R7 msg last");
    chip_en = 1'b1;
    @(negedge clk);
    chip_en = 1'b0;
    mreload();
    wait_skip("R8 msg wrap");
    run(40, "R8 msg after wrap");
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired act=running exp=done");
    finish_run();
  end

  initial begin
    jx = powmod(32'd16777232, 25'h0000009);
    jy = powmod(32'd16777232, 25'h000000F);
    midx = 0; mhold = 1'b0; mx = '0; my = '0; mcode = '0; mmode = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_idle();
    t_dpch_codes();
    t_hold();
    t_load_priority();
    t_dpch_wrap();
    t_msg();
    finish_run();
  end
endmodule